// File: doc/BRIEF.md
# Real-Time Clock with Time-of-Day and Sub-Second Alarms

This block keeps wall time inside one system clock domain. It is paced by a one-cycle reference strobe that arrives at 4096 Hz. Sixteen strobes make one 256 Hz tick. On each tick an 8-bit fraction counter advances, and a 32-bit seconds counter steps each time the fraction counter wraps. Two alarms run from the same ticks. The first is a time-of-day match against the low 20 bits of the seconds count. The second is a repeating countdown that reloads itself each time it expires.

Software reaches the block through a word-indexed register port with separate read and write strobes. Read data is registered. Alarm flags and a ready indication feed a single level interrupt through individual enables. A square-wave pin can carry one of several rates derived from the counters, the reference strobe or the system clock.

Software must set a write-enable bit before it can load the counters, and a read-enable bit before it can read them back. After any load of a counter or an alarm register, a short busy window rejects further loads of those registers.

Top module: `rtc_timer_top`

## Requirements
- R1: While counting is enabled (control bit 0), the fraction counter (word 1) advances by one on every 16th reference strobe, and holds between those strobes.
- R2: The seconds counter (word 0) increases by one in the same cycle that the fraction counter wraps from 0xFF to 0x00.
- R3: While control bit 0 is low, both counters and the countdown hold their values for any number of strobes, and register reads and writes still take effect.
- R4: The time-of-day flag (control bit 6) sets when the seconds counter advances to a value whose low 20 bits equal the alarm word (word 2, bits 19:0).
- R5: A nonzero reload value N written to word 3 sets the countdown flag (control bit 7) on every Nth 256 Hz tick after the write. The countdown then reloads from N. A reload value of zero never sets the flag.
- R6: Flags are sticky. Writing 0 to a flag bit in the control word clears it, and writing 1 leaves it unchanged. The interrupt output equals (bit 6 AND bit 1) OR (bit 7 AND bit 2) OR (bit 4 AND bit 5).
- R7: Writes to words 0 and 1 are ignored unless control bit 15 is set. Reads of words 0 and 1 return zero unless control bit 14 is set.
- R8: An accepted write to word 0, 1, 2 or 3 holds the busy bit (control bit 3) high for exactly 4 following cycles. Writes to those words during that window are ignored.
- R9: The ready bit (control bit 4) sets on each fraction-counter advance and clears on the next reference strobe that does not advance it.
- R10: With control bit 8 set, the square-wave output follows the source chosen by bits 10:9: 0 gives fraction-counter bit 7 (1 Hz), 1 gives 512 Hz, 2 toggles on every reference strobe, and 3 gives the system clock divided by 8. Bit 5 of word 6 overrides the selection with the system clock divided by 2. With bit 8 clear, the output is low.
- R11: After reset, all counters, flags, enables and configuration read as zero, and the interrupt and square-wave outputs are low.
- R12: Read data appears on the cycle after the read strobe. Word 5 always reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick4k | input | 1 | One-cycle reference strobe at 4096 Hz |
| regAddr | input | 3 | Register word index |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| sqwOut | output | 1 | Square-wave output |

## Verification
The counters are exercised in three ways: with strobes delivered while counting is disabled, with strobe counts one short of and exactly at a tick boundary, and from a preloaded 0xFF fraction value. Together these separate holding, off-by-one prescaling and a missing carry. The alarms are driven by a seconds value that steps onto the match and by a three-tick reload that runs over two periods. Those runs show whether an alarm fires on the matching value, whether the flag is sticky and masked, and whether the countdown reloads. The square-wave modes are told apart by counting output toggles over a fixed number of cycles or strobes. Each rate gives a different toggle count.

// File: rtl/rtc_timer_pkg.sv
package rtc_timer_pkg;

  // word indices of the register port
  localparam logic [2:0] IDX_SEC  = 3'd0;
  localparam logic [2:0] IDX_SUB  = 3'd1;
  localparam logic [2:0] IDX_TOD  = 3'd2;
  localparam logic [2:0] IDX_RLD  = 3'd3;
  localparam logic [2:0] IDX_CTL  = 3'd4;
  localparam logic [2:0] IDX_TRIM = 3'd5;
  localparam logic [2:0] IDX_OSC  = 3'd6;

  // square-wave source codes (control bits 10:9)
  typedef enum logic [1:0] {
    SQ_ONE_HZ  = 2'd0,
    SQ_512_HZ  = 2'd1,
    SQ_STROBE  = 2'd2,
    SQ_CLK_DIV = 2'd3
  } sqSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick256;
    logic wrSec;
    logic wrSub;
    logic wrTod;
    logic wrReload;
  } dpCmd_t;

endpackage

// File: rtl/rtc_timer_dp.sv
module rtc_timer_dp
  import rtc_timer_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 8,
  parameter int TOD_W = 20,
  parameter int RLD_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [31:0]      wdata,
  output logic [SEC_W-1:0] secVal,
  output logic [SUB_W-1:0] subVal,
  output logic [TOD_W-1:0] todVal,
  output logic [RLD_W-1:0] reloadVal,
  output logic             todHit,
  output logic             ssHit
);

  logic [SEC_W-1:0] secCnt;
  logic [SUB_W-1:0] subCnt;
  logic [TOD_W-1:0] todAlarm;
  logic [RLD_W-1:0] ssReload;
  logic [RLD_W-1:0] ssDown;
  logic [SEC_W-1:0] secNext;
  logic             carry;
  logic             ssActive;

  assign secNext  = secCnt + 1'b1;
  assign carry    = cmd.tick256 && (subCnt == '1) && !cmd.wrSub && !cmd.wrSec;
  assign todHit   = carry && (secNext[TOD_W-1:0] == todAlarm);
  assign ssActive = cmd.tick256 && (ssReload != '0) && !cmd.wrReload;
  assign ssHit    = ssActive && (ssDown <= RLD_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCnt <= '0;
      subCnt <= '0;
    end else begin
      if (cmd.wrSec)      secCnt <= wdata[SEC_W-1:0];
      else if (carry)     secCnt <= secNext;
      if (cmd.wrSub)      subCnt <= wdata[SUB_W-1:0];
      else if (cmd.tick256) subCnt <= subCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      todAlarm <= '0;
      ssReload <= '0;
      ssDown   <= '0;
    end else begin
      if (cmd.wrTod) todAlarm <= wdata[TOD_W-1:0];
      if (cmd.wrReload) begin
        ssReload <= wdata[RLD_W-1:0];
        ssDown   <= wdata[RLD_W-1:0];
      end else if (ssHit) begin
        ssDown <= ssReload;
      end else if (ssActive) begin
        ssDown <= ssDown - 1'b1;
      end
    end
  end

  assign secVal    = secCnt;
  assign subVal    = subCnt;
  assign todVal    = todAlarm;
  assign reloadVal = ssReload;

  // R3: without a tick or a load the fraction counter does not move
  a_r3_sub_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.tick256 && !cmd.wrSub) |=> $stable(subCnt));

  // R2: wrap of the fraction counter carries into seconds
  a_r2_carry: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.tick256 && subCnt == '1 && !cmd.wrSub && !cmd.wrSec)
      |=> (secCnt == $past(secCnt) + 1'b1) && (subCnt == '0));

  // R4: an alarm hit leaves seconds equal to the alarm value
  a_r4_tod_match: assert property (@(posedge clk) disable iff (!rstN)
    (todHit && !cmd.wrTod) |=> (secCnt[TOD_W-1:0] == todAlarm));

  // R5: on expiry the countdown restarts from the reload value
  a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
    ssHit |=> (ssDown == $past(ssReload)));

endmodule

// File: rtl/rtc_timer_ctrl.sv
module rtc_timer_ctrl
  import rtc_timer_pkg::*;
#(
  parameter int PRE_W    = 4,
  parameter int SEC_W    = 32,
  parameter int SUB_W    = 8,
  parameter int TOD_W    = 20,
  parameter int RLD_W    = 32,
  parameter int BUSY_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick4k,
  input  logic [2:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [31:0]      regWdata,
  input  logic [SEC_W-1:0] secVal,
  input  logic [SUB_W-1:0] subVal,
  input  logic [TOD_W-1:0] todVal,
  input  logic [RLD_W-1:0] reloadVal,
  input  logic             todHit,
  input  logic             ssHit,
  output dpCmd_t           cmd,
  output logic [31:0]      regRdata,
  output logic             irq,
  output logic             sqwOut
);

  localparam int BUSY_W = $clog2(BUSY_CYC + 1);
  localparam int DIV_W  = 3;

  logic [PRE_W-1:0]  pre;
  logic [BUSY_W-1:0] busyCnt;
  logic [DIV_W-1:0]  clkDiv;
  logic              busy;
  logic              cntEn, todIe, ssIe, readyIe;
  logic              todFlag, ssFlag, ready;
  logic              sqwEn, rdEn, wrEn, fastSq, tog4k;
  sqSel_e            sqwSel;
  logic              tick256;
  logic              cntWrOk, almWrOk, ctrlWr, oscWr;
  logic              sqSrc;
  logic [31:0]       ctrlWord;
  logic              unusedWdata;

  assign unusedWdata = ^{regWdata[31:16], regWdata[13:11], regWdata[4:3]};

  assign busy    = (busyCnt != '0);
  assign tick256 = tick4k && cntEn && (pre == '1);
  assign cntWrOk = regWr && !busy && wrEn && (regAddr == IDX_SEC || regAddr == IDX_SUB);
  assign almWrOk = regWr && !busy && (regAddr == IDX_TOD || regAddr == IDX_RLD);
  assign ctrlWr  = regWr && (regAddr == IDX_CTL);
  assign oscWr   = regWr && (regAddr == IDX_OSC);

  always_comb begin
    cmd          = '0;
    cmd.tick256  = tick256;
    cmd.wrSec    = cntWrOk && (regAddr == IDX_SEC);
    cmd.wrSub    = cntWrOk && (regAddr == IDX_SUB);
    cmd.wrTod    = almWrOk && (regAddr == IDX_TOD);
    cmd.wrReload = almWrOk && (regAddr == IDX_RLD);
  end

  // prescaler, busy window, free-running divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre     <= '0;
      busyCnt <= '0;
      clkDiv  <= '0;
      tog4k   <= 1'b0;
    end else begin
      clkDiv <= clkDiv + 1'b1;
      if (tick4k) tog4k <= ~tog4k;
      if (tick4k && cntEn) pre <= pre + 1'b1;
      if (cntWrOk || almWrOk) busyCnt <= BUSY_W'(BUSY_CYC);
      else if (busy)          busyCnt <= busyCnt - 1'b1;
    end
  end

  // control and oscillator configuration, flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn   <= 1'b0; todIe  <= 1'b0; ssIe  <= 1'b0; readyIe <= 1'b0;
      todFlag <= 1'b0; ssFlag <= 1'b0; ready <= 1'b0;
      sqwEn   <= 1'b0; sqwSel <= SQ_ONE_HZ;
      rdEn    <= 1'b0; wrEn   <= 1'b0; fastSq <= 1'b0;
    end else begin
      if (ctrlWr) begin
        cntEn   <= regWdata[0];
        todIe   <= regWdata[1];
        ssIe    <= regWdata[2];
        readyIe <= regWdata[5];
        sqwEn   <= regWdata[8];
        sqwSel  <= sqSel_e'(regWdata[10:9]);
        rdEn    <= regWdata[14];
        wrEn    <= regWdata[15];
      end
      if (oscWr) fastSq <= regWdata[5];
      todFlag <= todHit | (todFlag & ~(ctrlWr & ~regWdata[6]));
      ssFlag  <= ssHit  | (ssFlag  & ~(ctrlWr & ~regWdata[7]));
      if (tick256)     ready <= 1'b1;
      else if (tick4k) ready <= 1'b0;
    end
  end

  always_comb begin
    if (fastSq) sqSrc = clkDiv[0];
    else begin
      unique case (sqwSel)
        SQ_ONE_HZ:  sqSrc = subVal[SUB_W-1];
        SQ_512_HZ:  sqSrc = pre[PRE_W-2];
        SQ_STROBE:  sqSrc = tog4k;
        default:    sqSrc = clkDiv[DIV_W-1];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sqwOut <= 1'b0;
    else       sqwOut <= sqwEn & sqSrc;
  end

  assign ctrlWord = {16'b0, wrEn, rdEn, 3'b0, sqwSel, sqwEn, ssFlag, todFlag,
                     readyIe, ready, busy, ssIe, todIe, cntEn};

  always_ff @(posedge clk) begin
    if (!rstN) regRdata <= '0;
    else if (regRd) begin
      unique case (regAddr)
        IDX_SEC: regRdata <= rdEn ? 32'(secVal) : '0;
        IDX_SUB: regRdata <= rdEn ? 32'(subVal) : '0;
        IDX_TOD: regRdata <= 32'(todVal);
        IDX_RLD: regRdata <= 32'(reloadVal);
        IDX_CTL: regRdata <= ctrlWord;
        IDX_OSC: regRdata <= {26'b0, fastSq, 5'b0};
        default: regRdata <= '0;
      endcase
    end
  end

  assign irq = (todFlag & todIe) | (ssFlag & ssIe) | (ready & readyIe);

  // R6: the interrupt never asserts without a pending flag
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (todFlag || ssFlag || ready));

  // R8: an accepted counter load opens the busy window
  a_r8_busy_open: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrSec || cmd.wrSub) |=> busy);

  // R8: no load reaches the datapath while busy
  a_r8_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(cmd.wrSec || cmd.wrSub || cmd.wrTod || cmd.wrReload));

  // R9: a fraction advance raises ready
  a_r9_ready_set: assert property (@(posedge clk) disable iff (!rstN)
    tick256 |=> ready);

  // R10: a disabled square wave stays low
  a_r10_sqw_off: assert property (@(posedge clk) disable iff (!rstN)
    !sqwEn |=> !sqwOut);

endmodule

// File: rtl/rtc_timer_top.sv
module rtc_timer_top
  import rtc_timer_pkg::*;
#(
  parameter int PRE_W    = 4,
  parameter int SEC_W    = 32,
  parameter int SUB_W    = 8,
  parameter int TOD_W    = 20,
  parameter int RLD_W    = 32,
  parameter int BUSY_CYC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick4k,
  input  logic [2:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irq,
  output logic        sqwOut
);

  dpCmd_t           cmd;
  logic [SEC_W-1:0] secVal;
  logic [SUB_W-1:0] subVal;
  logic [TOD_W-1:0] todVal;
  logic [RLD_W-1:0] reloadVal;
  logic             todHit;
  logic             ssHit;

  rtc_timer_ctrl #(
    .PRE_W(PRE_W), .SEC_W(SEC_W), .SUB_W(SUB_W), .TOD_W(TOD_W),
    .RLD_W(RLD_W), .BUSY_CYC(BUSY_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .tick4k(tick4k), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .secVal(secVal), .subVal(subVal), .todVal(todVal), .reloadVal(reloadVal),
    .todHit(todHit), .ssHit(ssHit), .cmd(cmd),
    .regRdata(regRdata), .irq(irq), .sqwOut(sqwOut)
  );

  rtc_timer_dp #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .TOD_W(TOD_W), .RLD_W(RLD_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wdata(regWdata),
    .secVal(secVal), .subVal(subVal), .todVal(todVal), .reloadVal(reloadVal),
    .todHit(todHit), .ssHit(ssHit)
  );

endmodule

// File: tb/sim_rtc_timer_top.sv
module sim_rtc_timer_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick4k = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;
  logic        sqwOut;

  int checks = 0;
  int errors = 0;
  int preModel = 0;
  bit enModel = 1'b0;

  localparam logic [31:0] C_EN  = 32'h1;
  localparam logic [31:0] C_TIE = 32'h2;
  localparam logic [31:0] C_SIE = 32'h4;
  localparam logic [31:0] C_RIE = 32'h20;
  localparam logic [31:0] C_TF  = 32'h40;
  localparam logic [31:0] C_SQ  = 32'h100;
  localparam logic [31:0] C_RE  = 32'h4000;
  localparam logic [31:0] C_WE  = 32'h8000;

  always #10 clk = ~clk;

  rtc_timer_top u0 (
    .clk(clk), .rstN(rstN), .tick4k(tick4k), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .sqwOut(sqwOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic wrIdle(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    idle(6);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic setCtrl(input logic [31:0] v);
    wr(3'd4, v);
    idle(1);
    enModel = v[0];
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      tick4k = 1'b1;
      @(negedge clk);
      tick4k = 1'b0;
      @(negedge clk);
      if (enModel) preModel = (preModel + 1) % 16;
    end
  endtask

  task automatic tickSub();
    strobe(16 - preModel);
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R11 sqwOut", 32'(sqwOut), 0);
    chk("R11 irq", 32'(irq), 0);
    rd(3'd4, d); chk("R11 control word", d, 0);
    rd(3'd6, d); chk("R11 osc word", d, 0);
    rd(3'd2, d); chk("R11 alarm word", d, 0);
  endtask

  task automatic testGating();
    logic [31:0] d;
    setCtrl(C_WE | C_RE);
    wrIdle(3'd0, 32'h55);
    rd(3'd0, d); chk("R7 write with enable", d, 32'h55);
    setCtrl(C_RE);
    wrIdle(3'd0, 32'h99);
    rd(3'd0, d); chk("R7 write without enable ignored", d, 32'h55);
    setCtrl(C_WE);
    rd(3'd0, d); chk("R7 read without enable is zero", d, 0);
    wrIdle(3'd5, 32'hFF);
    rd(3'd5, d); chk("R12 trim word zero", d, 0);
  endtask

  task automatic testBusy();
    logic [31:0] d;
    setCtrl(C_WE | C_RE);
    wr(3'd1, 32'h10);
    idle(3);
    rd(3'd4, d); chk("R8 busy in 4th cycle", 32'(d[3]), 1);
    rd(3'd4, d); chk("R8 busy ends after 4 cycles", 32'(d[3]), 0);
    wr(3'd1, 32'h11);
    wr(3'd1, 32'h22);
    idle(6);
    rd(3'd1, d); chk("R8 write during busy ignored", d, 32'h11);
  endtask

  task automatic testCount();
    logic [31:0] d;
    wrIdle(3'd1, 32'h0);
    setCtrl(C_WE | C_RE | C_EN);
    strobe(15);
    rd(3'd1, d); chk("R1 no advance after 15 strobes", d, 0);
    strobe(1);
    rd(3'd1, d); chk("R1 advance on 16th strobe", d, 1);
    strobe(16);
    rd(3'd1, d); chk("R1 second advance", d, 2);
  endtask

  task automatic testReady();
    logic [31:0] d;
    rd(3'd4, d); chk("R9 ready after advance", 32'(d[4]), 1);
    strobe(1);
    rd(3'd4, d); chk("R9 ready cleared by next strobe", 32'(d[4]), 0);
    setCtrl(C_WE | C_RE | C_EN | C_RIE);
    tickSub();
    chk("R6 ready interrupt", 32'(irq), 1);
    strobe(1);
    chk("R6 ready interrupt drops", 32'(irq), 0);
  endtask

  task automatic testHold();
    logic [31:0] d0, d1;
    setCtrl(C_WE | C_RE);
    rd(3'd1, d0);
    strobe(40);
    rd(3'd1, d1); chk("R3 fraction holds while disabled", d1, d0);
    wrIdle(3'd1, 32'h33);
    rd(3'd1, d1); chk("R3 writes work while disabled", d1, 32'h33);
  endtask

  task automatic testCarry();
    logic [31:0] d;
    wrIdle(3'd1, 32'hFF);
    wrIdle(3'd0, 32'h7);
    setCtrl(C_WE | C_RE | C_EN);
    tickSub();
    rd(3'd0, d); chk("R2 seconds carry", d, 8);
    rd(3'd1, d); chk("R2 fraction wraps", d, 0);
  endtask

  task automatic testTod();
    logic [31:0] d;
    setCtrl(C_WE | C_RE);
    wrIdle(3'd2, 32'h9);
    wrIdle(3'd1, 32'hFF);
    setCtrl(C_WE | C_RE | C_EN | C_TIE);
    chk("R6 no interrupt before match", 32'(irq), 0);
    tickSub();
    rd(3'd4, d);
    chk("R4 time-of-day flag", 32'(d[6]), 1);
    chk("R5 zero reload never flags", 32'(d[7]), 0);
    chk("R6 time-of-day interrupt", 32'(irq), 1);
    setCtrl(C_WE | C_RE | C_EN | C_TIE | C_TF);
    rd(3'd4, d); chk("R6 writing 1 keeps flag", 32'(d[6]), 1);
    setCtrl(C_WE | C_RE | C_EN | C_TIE);
    rd(3'd4, d); chk("R6 writing 0 clears flag", 32'(d[6]), 0);
    chk("R6 interrupt clears", 32'(irq), 0);
  endtask

  task automatic testCountdown();
    logic [31:0] d;
    setCtrl(C_WE | C_RE | C_EN);
    wrIdle(3'd3, 32'h3);
    tickSub(); tickSub();
    rd(3'd4, d); chk("R5 no flag after 2 ticks", 32'(d[7]), 0);
    tickSub();
    rd(3'd4, d); chk("R5 flag after 3 ticks", 32'(d[7]), 1);
    chk("R6 masked countdown flag", 32'(irq), 0);
    setCtrl(C_WE | C_RE | C_EN);
    rd(3'd4, d); chk("R6 countdown flag cleared", 32'(d[7]), 0);
    tickSub(); tickSub();
    rd(3'd4, d); chk("R5 reload no early flag", 32'(d[7]), 0);
    tickSub();
    rd(3'd4, d); chk("R5 flag after reload period", 32'(d[7]), 1);
    setCtrl(C_WE | C_RE | C_EN | C_SIE | 32'h80);
    chk("R6 countdown interrupt", 32'(irq), 1);
    wrIdle(3'd3, 32'h0);
    setCtrl(C_WE | C_RE);
  endtask

  task automatic cycleToggles(input int n, output int t);
    logic last;
    t = 0;
    last = sqwOut;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sqwOut !== last) t++;
      last = sqwOut;
    end
  endtask

  task automatic strobeToggles(input int n, output int t);
    logic last;
    t = 0;
    last = sqwOut;
    for (int i = 0; i < n; i++) begin
      strobe(1);
      if (sqwOut !== last) t++;
      last = sqwOut;
    end
  endtask

  task automatic testSquare();
    int t;
    setCtrl(C_WE | C_RE);
    wrIdle(3'd1, 32'h80);
    setCtrl(C_WE | C_RE | C_SQ);
    idle(1);
    chk("R10 1 Hz source high", 32'(sqwOut), 1);
    wrIdle(3'd1, 32'h00);
    chk("R10 1 Hz source low", 32'(sqwOut), 0);
    setCtrl(C_WE | C_RE | C_SQ | 32'h600);
    cycleToggles(16, t); chk("R10 clock/8 toggles", 32'(t), 4);
    setCtrl(C_WE | C_RE | C_SQ | 32'h400);
    strobeToggles(8, t); chk("R10 strobe-rate toggles", 32'(t), 8);
    setCtrl(C_WE | C_RE | C_SQ | 32'h200 | C_EN);
    strobeToggles(16, t); chk("R10 512 Hz toggles", 32'(t), 4);
    wrIdle(3'd6, 32'h20);
    cycleToggles(16, t); chk("R10 override clock/2 toggles", 32'(t), 16);
    setCtrl(C_WE | C_RE);
    idle(2);
    cycleToggles(8, t);
    chk("R10 disabled output low", 32'(sqwOut), 0);
    chk("R10 disabled output still", 32'(t), 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testGating();
    testBusy();
    testCount();
    testReady();
    testHold();
    testCarry();
    testTod();
    testCountdown();
    testSquare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule